// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a single bus master and one downstream memory or peripheral port. It watches two 32 MB alias windows. In these windows every 32-bit word stands for one bit of a 1 MB bit-band window, one window for SRAM and one for peripherals. An alias read returns only the addressed bit. An alias write changes only the addressed bit, using a locked read-modify-write on the downstream port. Any access outside the alias windows is forwarded unchanged, and that includes plain accesses to the bit-band windows themselves.

Instruction fetches are treated differently in each window. A fetch into the SRAM alias window is forwarded as it is, with no translation. A fetch into the peripheral alias window is refused with an error, and no downstream access is made.

Both sides use a valid/ready request channel carrying address, write flag, write data, byte enables and a fetch flag. Each side also has a one-cycle response pulse carrying read data and an error flag. The block handles one request at a time.

Top module: `bitband_xlat`

## Requirements
- R1: While reset is high and in the first cycle after it, `u_req_ready` is 1 and `u_rsp_valid`, `d_req_valid` and `d_lock` are all 0.
- R2: A data access into an alias window (SRAM alias base 0x22000000, peripheral alias base 0x42000000, each 32 MB) is sent downstream to the bit-band byte address. That address is the bit-band base (0x20000000 or 0x40000000) plus the alias offset divided by 32. The bit number is (alias offset / 4) mod 8. For example, 0x23FFFFE0 targets bit 0 of byte 0x200FFFFF.
- R3: An alias read returns the selected bit in bit 0 of `u_rsp_rdata`, and all other bits are 0. The downstream byte enable is one-hot on byte lane address[1:0] of the bit-band byte, and that lane holds bits lane*8 to lane*8+7 of the word.
- R4: An alias write reads the containing word, then writes it back with only the selected bit replaced by bit 0 of `u_req_wdata`. Write-data bits 31:1 have no effect, and the upstream response for the write carries read data 0.
- R5: Address bits [1:0] of an alias access do not change which bit is selected.
- R6: Accesses outside both alias windows, including plain accesses to the bit-band windows, reach downstream with identical address, write flag, data, byte enables and fetch flag. The downstream response is returned unchanged.
- R7: An instruction fetch into the SRAM alias window is forwarded untranslated, with its fetch flag kept.
- R8: An instruction fetch into the peripheral alias window gets a response with `u_rsp_err`=1 and read data 0 in the cycle after acceptance, and no downstream request is made.
- R9: `d_lock` is high from the read phase through the write phase of a read-modify-write. No upstream request is accepted while it is high.
- R10: A downstream error in the read phase of a read-modify-write cancels the write phase and is reported on `u_rsp_err`. An error in the write phase is also reported.
- R11: A stalled downstream request holds its address and write flag until it is accepted. Every accepted upstream request produces exactly one `u_rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_req_valid | input | 1 | Upstream request valid |
| u_req_ready | output | 1 | Upstream request accepted when high with valid |
| u_req_addr | input | 32 | Upstream byte address |
| u_req_write | input | 1 | Upstream write flag |
| u_req_wdata | input | 32 | Upstream write data |
| u_req_be | input | 4 | Upstream byte enables |
| u_req_ifetch | input | 1 | Upstream instruction-fetch flag |
| u_rsp_valid | output | 1 | Upstream response pulse |
| u_rsp_rdata | output | 32 | Upstream response read data |
| u_rsp_err | output | 1 | Upstream response error |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream request accepted |
| d_req_addr | output | 32 | Downstream byte address |
| d_req_write | output | 1 | Downstream write flag |
| d_req_wdata | output | 32 | Downstream write data |
| d_req_be | output | 4 | Downstream byte enables |
| d_req_ifetch | output | 1 | Downstream instruction-fetch flag |
| d_lock | output | 1 | Downstream port locked for a read-modify-write |
| d_rsp_valid | input | 1 | Downstream response pulse |
| d_rsp_rdata | input | 32 | Downstream response read data |
| d_rsp_err | input | 1 | Downstream response error |

## Verification
The bench sweeps every bit of the first 32 SRAM bit-band bytes and a set of peripheral bytes through alias writes and reads. It varies the junk in address bits [1:0] and in the upper write-data bits, and it stalls the downstream port at random. A wrong lane or bit index would flip a neighbouring bit, which the direct read-back of each word exposes. An address formula off by a shift would reach the wrong byte, which the captured downstream address and the 0x23FFFFE0 end case reveal.

Fetches into the peripheral alias window must produce no downstream traffic, and fetches into the SRAM alias window must keep their alias address. A design that treated both windows alike fails one of these checks. Errors are injected in the read phase and in the write phase of a read-modify-write. A design that still wrote after a failed read shows up in the downstream write count.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int LANE_W = $clog2(BE_W);
    localparam int BIT_W  = 3;

    typedef enum logic [1:0] {
        CLS_PASS,
        CLS_ALIAS,
        CLS_FAULT
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              ifetch;
    } bus_req_t;

    typedef struct packed {
        cls_e              cls;
        logic              rmw;
        logic [LANE_W-1:0] lane;
        logic [BIT_W-1:0]  bitn;
        logic              newbit;
        bus_req_t          fwd;
    } xlat_t;

    function automatic logic [LANE_W+BIT_W-1:0] bit_index(
        input logic [LANE_W-1:0] lane,
        input logic [BIT_W-1:0]  bitn
    );
        return {lane, bitn};
    endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SRAM_BB_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] SRAM_AL_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] PERI_BB_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] PERI_AL_BASE = 32'h4200_0000,
    parameter int                AL_SPAN_W    = 25
) (
    input  bus_req_t req,
    output xlat_t    x
);
    localparam int SHIFT_W = BIT_W + 2;
    localparam int OFF_W   = AL_SPAN_W - SHIFT_W;

    logic              in_sram;
    logic              in_peri;
    logic [ADDR_W-1:0] bb_addr;

    always_comb begin
        in_sram = (req.addr[ADDR_W-1:AL_SPAN_W] == SRAM_AL_BASE[ADDR_W-1:AL_SPAN_W]);
        in_peri = (req.addr[ADDR_W-1:AL_SPAN_W] == PERI_AL_BASE[ADDR_W-1:AL_SPAN_W]);
        bb_addr = (in_peri ? PERI_BB_BASE : SRAM_BB_BASE)
                + ADDR_W'(req.addr[AL_SPAN_W-1:SHIFT_W]);

        x        = '0;
        x.bitn   = req.addr[SHIFT_W-1:2];
        x.lane   = bb_addr[LANE_W-1:0];
        x.newbit = req.wdata[0];

        if ((in_sram || in_peri) && !req.ifetch) begin
            x.cls          = CLS_ALIAS;
            x.rmw          = req.write;
            x.fwd.addr     = bb_addr;
            x.fwd.write    = 1'b0;
            x.fwd.wdata    = '0;
            x.fwd.be       = BE_W'(1) << x.lane;
            x.fwd.ifetch   = 1'b0;
        end else if (in_peri && req.ifetch) begin
            x.cls = CLS_FAULT;
        end else begin
            x.cls = CLS_PASS;
            x.fwd = req;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{OFF_W[0]};
endmodule

// File: rtl/bb_bitmerge.sv
module bb_bitmerge
    import bb_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  logic [BIT_W-1:0]  bitn,
    input  logic              newbit,
    output logic              sel_bit,
    output logic [DATA_W-1:0] merged
);
    logic [LANE_W+BIT_W-1:0] idx;

    always_comb begin
        idx     = bit_index(lane, bitn);
        sel_bit = word[idx];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_merge
        assign merged[i] = (idx == (LANE_W+BIT_W)'(i)) ? newbit : word[i];
    end
endmodule

// File: rtl/bitband_xlat.sv
module bitband_xlat
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SRAM_BB_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] SRAM_AL_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] PERI_BB_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] PERI_AL_BASE = 32'h4200_0000,
    parameter int                AL_SPAN_W    = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              u_req_valid,
    output logic              u_req_ready,
    input  logic [ADDR_W-1:0] u_req_addr,
    input  logic              u_req_write,
    input  logic [DATA_W-1:0] u_req_wdata,
    input  logic [BE_W-1:0]   u_req_be,
    input  logic              u_req_ifetch,
    output logic              u_rsp_valid,
    output logic [DATA_W-1:0] u_rsp_rdata,
    output logic              u_rsp_err,
    output logic              d_req_valid,
    input  logic              d_req_ready,
    output logic [ADDR_W-1:0] d_req_addr,
    output logic              d_req_write,
    output logic [DATA_W-1:0] d_req_wdata,
    output logic [BE_W-1:0]   d_req_be,
    output logic              d_req_ifetch,
    output logic              d_lock,
    input  logic              d_rsp_valid,
    input  logic [DATA_W-1:0] d_rsp_rdata,
    input  logic              d_rsp_err
);
    st_e               st;
    xlat_t             x;
    xlat_t             dec_x;
    bus_req_t          up_req;
    logic              phase_wr;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_err;
    logic              sel_bit;
    logic [DATA_W-1:0] merged;

    assign up_req = '{addr: u_req_addr, write: u_req_write, wdata: u_req_wdata,
                      be: u_req_be, ifetch: u_req_ifetch};

    bb_decode #(
        .SRAM_BB_BASE(SRAM_BB_BASE),
        .SRAM_AL_BASE(SRAM_AL_BASE),
        .PERI_BB_BASE(PERI_BB_BASE),
        .PERI_AL_BASE(PERI_AL_BASE),
        .AL_SPAN_W   (AL_SPAN_W)
    ) i_decode (
        .req(up_req),
        .x  (dec_x)
    );

    bb_bitmerge i_merge (
        .word   (d_rsp_rdata),
        .lane   (x.lane),
        .bitn   (x.bitn),
        .newbit (x.newbit),
        .sel_bit(sel_bit),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            x        <= '0;
            phase_wr <= 1'b0;
            wr_word  <= '0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (u_req_valid) begin
                        x        <= dec_x;
                        phase_wr <= 1'b0;
                        if (dec_x.cls == CLS_FAULT) begin
                            rsp_data <= '0;
                            rsp_err  <= 1'b1;
                            st       <= ST_RESP;
                        end else begin
                            st <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (d_req_ready) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (d_rsp_valid) begin
                        if (x.rmw && !phase_wr && !d_rsp_err) begin
                            phase_wr <= 1'b1;
                            wr_word  <= merged;
                            st       <= ST_ISSUE;
                        end else begin
                            rsp_err <= d_rsp_err;
                            if (x.cls == CLS_ALIAS)
                                rsp_data <= x.rmw ? '0 : DATA_W'(sel_bit & ~d_rsp_err);
                            else
                                rsp_data <= d_rsp_rdata;
                            st <= ST_RESP;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        u_req_ready  = (st == ST_IDLE);
        u_rsp_valid  = (st == ST_RESP);
        u_rsp_rdata  = rsp_data;
        u_rsp_err    = rsp_err;
        d_req_valid  = (st == ST_ISSUE);
        d_req_addr   = x.fwd.addr;
        d_req_write  = x.fwd.write | phase_wr;
        d_req_wdata  = phase_wr ? wr_word : x.fwd.wdata;
        d_req_be     = x.fwd.be;
        d_req_ifetch = x.fwd.ifetch;
        d_lock       = x.rmw && ((st == ST_ISSUE) || (st == ST_WAIT));
    end
endmodule

// File: rtl/bb_chk.sv
module bb_chk
    import bb_pkg::*;
#(
    parameter int               TAG_W    = 7,
    parameter logic [TAG_W-1:0] SRAM_TAG = 7'h11,
    parameter logic [TAG_W-1:0] PERI_TAG = 7'h21
) (
    input logic              clk,
    input logic              rst,
    input logic              u_req_valid,
    input logic              u_req_ready,
    input logic [TAG_W-1:0]  u_req_tag,
    input logic              u_req_write,
    input logic              u_req_ifetch,
    input logic              u_rsp_valid,
    input logic [DATA_W-1:1] u_rsp_hi,
    input logic              u_rsp_err,
    input logic              d_req_valid,
    input logic              d_req_ready,
    input logic [ADDR_W-1:0] d_req_addr,
    input logic              d_req_write,
    input logic              d_lock
);
    logic accept;
    logic pend_ard;

    assign accept = u_req_valid && u_req_ready;

    always_ff @(posedge clk) begin
        if (rst) pend_ard <= 1'b0;
        else if (accept)
            pend_ard <= ((u_req_tag == SRAM_TAG) || (u_req_tag == PERI_TAG))
                        && !u_req_write && !u_req_ifetch;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> u_req_ready && !u_rsp_valid && !d_req_valid && !d_lock);

    // R3
    alias_rd_bit_chk: assert property (@(posedge clk) disable iff (rst)
        u_rsp_valid && pend_ard |-> (u_rsp_hi == '0));

    // R8
    fetch_fault_chk: assert property (@(posedge clk) disable iff (rst)
        accept && u_req_ifetch && (u_req_tag == PERI_TAG)
        |=> u_rsp_valid && u_rsp_err && !d_req_valid);

    // R9
    lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        d_lock |-> !u_req_ready);

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(d_lock) |-> u_rsp_valid);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        d_req_valid && !d_req_ready
        |=> d_req_valid && $stable(d_req_addr) && $stable(d_req_write));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        u_rsp_valid |=> !u_rsp_valid);
endmodule

bind bitband_xlat bb_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .u_req_valid (u_req_valid),
    .u_req_ready (u_req_ready),
    .u_req_tag   (u_req_addr[31:25]),
    .u_req_write (u_req_write),
    .u_req_ifetch(u_req_ifetch),
    .u_rsp_valid (u_rsp_valid),
    .u_rsp_hi    (u_rsp_rdata[31:1]),
    .u_rsp_err   (u_rsp_err),
    .d_req_valid (d_req_valid),
    .d_req_ready (d_req_ready),
    .d_req_addr  (d_req_addr),
    .d_req_write (d_req_write),
    .d_lock      (d_lock)
);

// File: tb/test_bitband_xlat.sv
`timescale 1ns/1ps
module test_bitband_xlat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        u_req_valid = 1'b0;
    logic        u_req_ready;
    logic [31:0] u_req_addr = '0;
    logic        u_req_write = 1'b0;
    logic [31:0] u_req_wdata = '0;
    logic [3:0]  u_req_be = '0;
    logic        u_req_ifetch = 1'b0;
    logic        u_rsp_valid;
    logic [31:0] u_rsp_rdata;
    logic        u_rsp_err;
    logic        d_req_valid;
    logic        d_req_ready;
    logic [31:0] d_req_addr;
    logic        d_req_write;
    logic [31:0] d_req_wdata;
    logic [3:0]  d_req_be;
    logic        d_req_ifetch;
    logic        d_lock;
    logic        d_rsp_valid = 1'b0;
    logic [31:0] d_rsp_rdata = '0;
    logic        d_rsp_err = 1'b0;

    always #2 clk = ~clk;

    bitband_xlat i_bitband_xlat (.*);

    // downstream model
    logic [31:0] mem [0:127];
    logic [31:0] sh  [0:127];
    logic [7:0]  lfsr = 8'hA5;
    logic        stall_en = 1'b0;
    logic [1:0]  err_mode = 2'd0;
    int          req_cnt = 0, wr_cnt = 0, lock_viol = 0;
    logic [31:0] last_addr = '0;
    logic [3:0]  last_be = '0;
    logic        last_if = 1'b0, last_wr = 1'b0, last_lock = 1'b0;

    int n_run = 0, n_fail = 0;

    function automatic logic [6:0] mi(input logic [31:0] a);
        return {a[30], a[7:2]};
    endfunction

    function automatic logic [31:0] seed(input int i);
        return 32'h9E37_79B9 * (i + 1);
    endfunction

    assign d_req_ready = stall_en ? lfsr[0] : 1'b1;

    always @(posedge clk) begin
        lfsr        <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        d_rsp_valid <= 1'b0;
        if (rst) begin
            for (int i = 0; i < 128; i++) mem[i] <= seed(i);
        end else begin
            if (d_lock && u_req_ready) lock_viol <= lock_viol + 1;
            if (d_req_valid && d_req_ready) begin
                logic e;
                e = (err_mode == 2'd1 && !d_req_write) || (err_mode == 2'd2 && d_req_write);
                req_cnt     <= req_cnt + 1;
                last_addr   <= d_req_addr;
                last_be     <= d_req_be;
                last_if     <= d_req_ifetch;
                last_wr     <= d_req_write;
                last_lock   <= d_lock;
                d_rsp_valid <= 1'b1;
                d_rsp_err   <= e;
                d_rsp_rdata <= mem[mi(d_req_addr)];
                if (d_req_write) begin
                    wr_cnt <= wr_cnt + 1;
                    if (!e)
                        for (int b = 0; b < 4; b++)
                            if (d_req_be[b]) mem[mi(d_req_addr)][b*8 +: 8] <= d_req_wdata[b*8 +: 8];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [31:0] a, input logic w, input logic [31:0] wd,
                       input logic [3:0] be, input logic f,
                       output logic [31:0] rd, output logic er);
        logic r;
        @(negedge clk);
        u_req_valid = 1'b1; u_req_addr = a; u_req_write = w;
        u_req_wdata = wd; u_req_be = be; u_req_ifetch = f;
        forever begin
            r = u_req_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        #1 u_req_valid = 1'b0;
        do @(negedge clk); while (!u_rsp_valid);
        rd = u_rsp_rdata;
        er = u_rsp_err;
        @(negedge clk);
        chk("R11 single response pulse", {31'b0, u_rsp_valid}, 32'd0);
    endtask

    // alias write then read of one bit, shadow updated
    task automatic bit_rw(input logic [31:0] al_base, input logic [31:0] bb_base,
                          input int off, input int b, input logic v);
        logic [31:0] a, bb, rd;
        logic        er;
        a  = al_base + off * 32 + b * 4;
        bb = bb_base + off;
        acc(a | ((off + b) & 3), 1'b1, {31'h2AD5_5A5A, v}, 4'h0, 1'b0, rd, er);
        chk("R4 alias write no error", {31'b0, er}, 32'd0);
        chk("R4 alias write rdata zero", rd, 32'd0);
        chk("R2 write target byte addr", last_addr, bb);
        chk("R9 lock on write phase", {30'b0, last_lock, last_wr}, 32'd3);
        chk("R3 one-hot lane enable", {28'b0, last_be}, 32'd1 << bb[1:0]);
        sh[mi(bb)][bb[1:0]*8 + b] = v;
        acc(a | ((off + 2 * b + 1) & 3), 1'b0, 32'hFFFF_FFFF, 4'hF, 1'b0, rd, er);
        chk("R3 R5 alias read bit", rd, {31'b0, v});
        chk("R2 read target byte addr", last_addr, bb);
    endtask

    initial begin
        logic [31:0] rd, ex;
        logic        er;
        int          snap;
        for (int i = 0; i < 128; i++) sh[i] = seed(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", {31'b0, u_req_ready}, 32'd1);
        chk("R1 idle outputs in reset", {29'b0, u_rsp_valid, d_req_valid, d_lock}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, u_req_ready}, 32'd1);
        chk("R1 idle after reset", {29'b0, u_rsp_valid, d_req_valid, d_lock}, 32'd0);

        stall_en = 1'b1;
        // SRAM alias sweep: every bit of bytes 0..31
        for (int off = 0; off < 32; off++) begin
            for (int b = 0; b < 8; b++)
                bit_rw(32'h2200_0000, 32'h2000_0000, off, b, 1'((off ^ (b * 5) ^ (off >> 2)) & 1));
            if ((off & 3) == 3) begin
                acc(32'h2000_0000 + (off & ~3), 1'b0, 0, 4'hF, 1'b0, rd, er);
                chk("R4 word after SRAM bit writes", rd, sh[mi(32'h2000_0000 + (off & ~3))]);
            end
        end
        // peripheral alias sweep
        for (int off = 0; off < 8; off++) begin
            for (int k = 0; k < 3; k++)
                bit_rw(32'h4200_0000, 32'h4000_0000, off, (k == 0) ? 0 : (k == 1) ? 3 : 7,
                       1'(~(off + k) & 1));
            if ((off & 3) == 3) begin
                acc(32'h4000_0000 + (off & ~3), 1'b0, 0, 4'hF, 1'b0, rd, er);
                chk("R4 word after peripheral bit writes", rd, sh[mi(32'h4000_0000 + (off & ~3))]);
            end
        end

        // R2 top-of-window cases
        acc(32'h23FF_FFE0, 1'b0, 0, 4'hF, 1'b0, rd, er);
        chk("R2 0x23FFFFE0 maps to 0x200FFFFF", last_addr, 32'h200F_FFFF);
        chk("R2 0x23FFFFE0 bit 0 of lane 3", rd, {31'b0, sh[mi(32'h200F_FFFF)][24]});
        acc(32'h43FF_FFFC, 1'b0, 0, 4'hF, 1'b0, rd, er);
        chk("R2 0x43FFFFFC maps to 0x400FFFFF", last_addr, 32'h400F_FFFF);
        chk("R2 0x43FFFFFC bit 7 of lane 3", rd, {31'b0, sh[mi(32'h400F_FFFF)][31]});

        // R6 pass-through
        acc(32'h4000_0010, 1'b1, 32'hCAFE_F00D, 4'b0101, 1'b0, rd, er);
        chk("R6 direct write addr", last_addr, 32'h4000_0010);
        chk("R6 direct write be/wr/lock", {26'b0, last_be, last_wr, last_lock}, {26'b0, 4'b0101, 2'b10});
        sh[mi(32'h4000_0010)][7:0]   = 8'h0D;
        sh[mi(32'h4000_0010)][23:16] = 8'hFE;
        acc(32'h4000_0010, 1'b0, 0, 4'hF, 1'b0, rd, er);
        chk("R6 direct read back", rd, sh[mi(32'h4000_0010)]);
        acc(32'h1000_0024, 1'b0, 0, 4'hF, 1'b0, rd, er);
        chk("R6 outside window addr", last_addr, 32'h1000_0024);
        chk("R6 outside window data", rd, sh[mi(32'h1000_0024)]);

        // R7 SRAM alias fetch forwarded
        acc(32'h2200_0040, 1'b0, 0, 4'hF, 1'b1, rd, er);
        chk("R7 fetch addr untranslated", last_addr, 32'h2200_0040);
        chk("R7 fetch flag kept", {31'b0, last_if}, 32'd1);
        chk("R7 fetch word data", rd, sh[mi(32'h2200_0040)]);

        // R8 peripheral alias fetch refused
        snap = req_cnt;
        acc(32'h4200_0100, 1'b0, 0, 4'hF, 1'b1, rd, er);
        chk("R8 fetch error", {31'b0, er}, 32'd1);
        chk("R8 fetch data zero", rd, 32'd0);
        chk("R8 no downstream access", req_cnt, snap);

        // R10 error handling
        stall_en = 1'b0;
        snap = wr_cnt;
        err_mode = 2'd1;
        ex = sh[mi(32'h2000_0004)];
        acc(32'h2200_0000 + 5 * 32 + 2 * 4, 1'b1, {31'b0, ~ex[8 + 2]}, 4'h0, 1'b0, rd, er);
        chk("R10 read-phase error reported", {31'b0, er}, 32'd1);
        chk("R10 write aborted", wr_cnt, snap);
        acc(32'h2200_0000 + 5 * 32, 1'b0, 0, 4'hF, 1'b0, rd, er);
        chk("R10 alias read error", {31'b0, er}, 32'd1);
        err_mode = 2'd2;
        acc(32'h2200_0000 + 5 * 32 + 2 * 4, 1'b1, {31'b0, ~ex[8 + 2]}, 4'h0, 1'b0, rd, er);
        chk("R10 write-phase error reported", {31'b0, er}, 32'd1);
        chk("R10 write phase issued", wr_cnt, snap + 1);
        err_mode = 2'd0;
        acc(32'h2000_0004, 1'b0, 0, 4'hF, 1'b0, rd, er);
        chk("R10 word unchanged after errors", rd, ex);
        chk("R10 clean read no error", {31'b0, er}, 32'd0);

        chk("R9 no accept while locked", lock_viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule